// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the register state of a small 32-bit processor whose visible registers depend on a 5-bit operating-mode code. Sixteen logical registers, r0 to r15, are addressed by a 4-bit index. The mode selects which physical copy each logical index refers to. The fast-interrupt mode keeps private copies of the upper seven general registers. The four other exception modes keep private copies only of the stack pointer (r13) and link register (r14). The system mode works on the plain user set. r15 serves as the program counter, and its low bits read back according to the current instruction width.

The block has two combinational read ports and one clocked write port, all interpreted under the current mode. Each exception mode also owns a saved status register, which is read and written under that same mode. A second clocked write port carries its own mode code and always targets the link register of that mode. An exception-entry sequencer uses it to store a return address into the new mode's bank in the same cycle as an ordinary register write.

Top module: `bankreg_file`

## Requirements
- R1: After reset every physical register and every saved status register reads as zero.
- R2: Both read ports are combinational. A write through the main port lands at the next rising clock edge, so a read of the register being written returns the old value until that edge.
- R3: User mode (10000), system mode (11111) and any code that is not one of the seven listed mode codes all see one shared set of sixteen registers.
- R4: In fast-interrupt mode (10001), indices 8 to 14 select a private copy that no other mode sees. Indices 0 to 7 and 15 select the shared user registers.
- R5: In interrupt mode (10010), supervisor mode (10011), abort mode (10111) and undefined mode (11011), indices 13 and 14 select a copy private to that one mode. Indices 0 to 12 and 15 select the shared user registers.
- R6: The full written value of r15 is stored. A read of index 15 returns bits [1:0] as zero when narrow_isa_i is 0, and bit [0] as zero when narrow_isa_i is 1. No other index is altered.
- R7: Each of the five exception modes has its own saved status register. A write under one of these modes is seen only by reads under that same mode.
- R8: Under user mode, system mode or an unrecognised code, the saved status read returns zero, and a saved status write changes no saved status register.
- R9: The auxiliary write port writes index 14 as mapped under aux_wr_mode, at the same edge as any main write. When both ports hit the same physical register, the auxiliary value is the one kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current operating-mode code |
| narrow_isa_i | input | 1 | 1 when executing 16-bit instructions, 0 for 32-bit |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Main write enable |
| wr_idx | input | 4 | Main write logical index |
| wr_data | input | 32 | Main write data |
| aux_wr_en | input | 1 | Auxiliary link-register write enable |
| aux_wr_mode | input | 5 | Mode code whose link register the auxiliary port writes |
| aux_wr_data | input | 32 | Auxiliary write data |
| sv_rd_data | output | 32 | Saved status register of the current mode |
| sv_wr_en | input | 1 | Saved status write enable |
| sv_wr_data | input | 32 | Saved status write data |

## Verification
The bench builds the block with its defaults: 32-bit data, the fast-interrupt bank starting at index 8, and program-counter alignment enabled. With these values the bench can exercise the full 31-entry physical layout. Writing every bank with distinct values exposes any aliasing between the seven-entry fast bank, the four two-entry banks and the shared set. The narrow-isa input exercises both masking widths on r15.

// File: rtl/bankreg_pkg.sv
`timescale 1ns/1ps
package bankreg_pkg;

   localparam int unsigned MODE_W = 5;
   localparam int unsigned IDX_W  = 4;
   localparam int unsigned N_EXC  = 5;

   localparam logic [MODE_W-1:0] MD_USER   = 5'b10000;
   localparam logic [MODE_W-1:0] MD_FAST   = 5'b10001;
   localparam logic [MODE_W-1:0] MD_INTR   = 5'b10010;
   localparam logic [MODE_W-1:0] MD_SUPV   = 5'b10011;
   localparam logic [MODE_W-1:0] MD_ABORT  = 5'b10111;
   localparam logic [MODE_W-1:0] MD_UNDEF  = 5'b11011;
   localparam logic [MODE_W-1:0] MD_SYSTEM = 5'b11111;

   // bank order: the four two-register banks must stay contiguous after BK_FAST
   typedef enum logic [2:0] {
      BK_USER  = 3'd0,
      BK_FAST  = 3'd1,
      BK_INTR  = 3'd2,
      BK_SUPV  = 3'd3,
      BK_ABORT = 3'd4,
      BK_UNDEF = 3'd5
   } bank_e;

   function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
      bank_e b;
      case (m)
         MD_FAST:  b = BK_FAST;
         MD_INTR:  b = BK_INTR;
         MD_SUPV:  b = BK_SUPV;
         MD_ABORT: b = BK_ABORT;
         MD_UNDEF: b = BK_UNDEF;
         default:  b = BK_USER;   // user, system and unknown codes
      endcase
      return b;
   endfunction

endpackage

// File: rtl/bankreg_map.sv
`timescale 1ns/1ps
module bankreg_map
   import bankreg_pkg::*;
#(
   parameter int unsigned FAST_LO = 8,
   parameter int unsigned PHYS_W  = 5
) (
   input  bank_e                bank_i,
   input  logic [IDX_W-1:0]     idx_i,
   output logic [PHYS_W-1:0]    phys_o
);

   localparam int FAST_CNT  = 15 - int'(FAST_LO);
   localparam int PAIR_BASE = 16 + FAST_CNT;
   localparam int SP_IDX    = 13;
   localparam int LR_IDX    = 14;

   int ii;
   int bb;

   always_comb begin
      ii     = int'(idx_i);
      bb     = int'(bank_i);
      phys_o = PHYS_W'(ii);
      case (bank_i)
         BK_FAST: begin
            if (ii >= int'(FAST_LO) && ii <= LR_IDX)
               phys_o = PHYS_W'(16 + ii - int'(FAST_LO));
         end
         BK_INTR, BK_SUPV, BK_ABORT, BK_UNDEF: begin
            if (ii >= SP_IDX && ii <= LR_IDX)
               phys_o = PHYS_W'(PAIR_BASE + 2 * (bb - int'(BK_INTR)) + (ii - SP_IDX));
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bankreg_store.sv
`timescale 1ns/1ps
module bankreg_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N_PHYS = 31,
   parameter int unsigned PHYS_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_main,
   input  logic [PHYS_W-1:0] wa_main,
   input  logic [DATA_W-1:0] wd_main,
   input  logic              we_aux,
   input  logic [PHYS_W-1:0] wa_aux,
   input  logic [DATA_W-1:0] wd_aux,
   input  logic [PHYS_W-1:0] ra_0,
   output logic [DATA_W-1:0] rd_0,
   input  logic [PHYS_W-1:0] ra_1,
   output logic [DATA_W-1:0] rd_1
);

   logic [DATA_W-1:0] mem [N_PHYS];

   for (genvar g = 0; g < N_PHYS; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (we_aux && wa_aux == PHYS_W'(g))
            mem[g] <= wd_aux;
         else if (we_main && wa_main == PHYS_W'(g))
            mem[g] <= wd_main;
      end
   end

   assign rd_0 = mem[ra_0];
   assign rd_1 = mem[ra_1];

endmodule

// File: rtl/bankreg_sv_bank.sv
`timescale 1ns/1ps
module bankreg_sv_bank
   import bankreg_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bank_e             bank_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wd_i,
   output logic [DATA_W-1:0] rd_o
);

   logic [DATA_W-1:0] sv [N_EXC];

   for (genvar g = 0; g < N_EXC; g++) begin : g_sv
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sv[g] <= '0;
         else if (we_i && int'(bank_i) == g + 1)
            sv[g] <= wd_i;
      end
   end

   always_comb begin
      rd_o = '0;
      for (int k = 0; k < int'(N_EXC); k++)
         if (int'(bank_i) == k + 1)
            rd_o = sv[k];
   end

endmodule

// File: rtl/bankreg_file.sv
`timescale 1ns/1ps
module bankreg_file
   import bankreg_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned FAST_LO     = 8,
   parameter bit          PC_ALIGN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        mode_i,
   input  logic              narrow_isa_i,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              aux_wr_en,
   input  logic [4:0]        aux_wr_mode,
   input  logic [DATA_W-1:0] aux_wr_data,
   output logic [DATA_W-1:0] sv_rd_data,
   input  logic              sv_wr_en,
   input  logic [DATA_W-1:0] sv_wr_data
);

   localparam int unsigned FAST_CNT = 15 - FAST_LO;
   localparam int unsigned N_PAIR   = 4;
   localparam int unsigned N_PHYS   = 16 + FAST_CNT + 2 * N_PAIR;
   localparam int unsigned PHYS_W   = $clog2(N_PHYS);
   localparam int unsigned N_PORT   = 4;
   localparam int unsigned P_RDA    = 0;
   localparam int unsigned P_RDB    = 1;
   localparam int unsigned P_WR     = 2;
   localparam int unsigned P_AUX    = 3;
   localparam logic [3:0]  PC_IDX   = 4'hF;
   localparam logic [3:0]  LR_IDX   = 4'hE;

   if (DATA_W < 2) begin : g_bad_width
      $error("bankreg_file: DATA_W must be at least 2");
   end
   if (FAST_LO < 1 || FAST_LO > 13) begin : g_bad_fast_lo
      $error("bankreg_file: FAST_LO must lie in 1..13");
   end

   bank_e cur_bank;
   bank_e aux_bank;
   assign cur_bank = bank_of(mode_i);
   assign aux_bank = bank_of(aux_wr_mode);

   logic [3:0]        port_idx  [N_PORT];
   bank_e             port_bank [N_PORT];
   logic [PHYS_W-1:0] port_phys [N_PORT];

   assign port_idx[P_RDA] = rd_a_idx;
   assign port_idx[P_RDB] = rd_b_idx;
   assign port_idx[P_WR]  = wr_idx;
   assign port_idx[P_AUX] = LR_IDX;

   for (genvar p = 0; p < N_PORT; p++) begin : g_map
      assign port_bank[p] = (p == P_AUX) ? aux_bank : cur_bank;
      bankreg_map #(
         .FAST_LO (FAST_LO),
         .PHYS_W  (PHYS_W)
      ) u_map (
         .bank_i (port_bank[p]),
         .idx_i  (port_idx[p]),
         .phys_o (port_phys[p])
      );
   end

   logic [DATA_W-1:0] raw_a;
   logic [DATA_W-1:0] raw_b;

   bankreg_store #(
      .DATA_W (DATA_W),
      .N_PHYS (N_PHYS),
      .PHYS_W (PHYS_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_main (wr_en),
      .wa_main (port_phys[P_WR]),
      .wd_main (wr_data),
      .we_aux  (aux_wr_en),
      .wa_aux  (port_phys[P_AUX]),
      .wd_aux  (aux_wr_data),
      .ra_0    (port_phys[P_RDA]),
      .rd_0    (raw_a),
      .ra_1    (port_phys[P_RDB]),
      .rd_1    (raw_b)
   );

   if (PC_ALIGN_EN) begin : g_pc_align
      always_comb begin
         rd_a_data = raw_a;
         rd_b_data = raw_b;
         if (rd_a_idx == PC_IDX)
            rd_a_data[1:0] = {raw_a[1] & narrow_isa_i, 1'b0};
         if (rd_b_idx == PC_IDX)
            rd_b_data[1:0] = {raw_b[1] & narrow_isa_i, 1'b0};
      end
   end else begin : g_pc_raw
      assign rd_a_data = raw_a;
      assign rd_b_data = raw_b;
   end

   bankreg_sv_bank #(
      .DATA_W (DATA_W)
   ) u_sv (
      .clk    (clk),
      .rst_n  (rst_n),
      .bank_i (cur_bank),
      .we_i   (sv_wr_en),
      .wd_i   (sv_wr_data),
      .rd_o   (sv_rd_data)
   );

endmodule

// File: rtl/bankreg_file_chk.sv
`timescale 1ns/1ps
module bankreg_file_chk
   import bankreg_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter bit          PC_ALIGN_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        mode_i,
   input logic              narrow_isa_i,
   input logic [3:0]        rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [3:0]        rd_b_idx,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              wr_en,
   input logic [3:0]        wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              aux_wr_en,
   input logic [4:0]        aux_wr_mode,
   input logic [DATA_W-1:0] aux_wr_data,
   input logic [DATA_W-1:0] sv_rd_data,
   input logic              sv_wr_en,
   input logic [DATA_W-1:0] sv_wr_data
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;

   // R2
   wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(wr_en) && !$past(aux_wr_en) && $past(wr_idx) != 4'hF
       && mode_i == $past(mode_i) && rd_a_idx == $past(wr_idx))
      |-> rd_a_data == $past(wr_data));

   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(wr_en) && !$past(aux_wr_en) && $stable(mode_i)
       && $stable(rd_a_idx) && $stable(narrow_isa_i))
      |-> $stable(rd_a_data));

   // R9
   aux_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(aux_wr_en) && rd_b_idx == 4'hE
       && bank_of(mode_i) == bank_of($past(aux_wr_mode)))
      |-> rd_b_data == $past(aux_wr_data));

   // R7
   sv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(sv_wr_en) && mode_i == $past(mode_i)
       && bank_of(mode_i) != BK_USER)
      |-> sv_rd_data == $past(sv_wr_data));

   // R8
   sv_user_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_of(mode_i) == BK_USER) |-> sv_rd_data == '0);

   if (PC_ALIGN_EN) begin : g_pc_chk
      // R6
      pc_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!narrow_isa_i && rd_a_idx == 4'hF) |-> rd_a_data[1:0] == 2'b00);
      // R6
      pc_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (narrow_isa_i && rd_b_idx == 4'hF) |-> rd_b_data[0] == 1'b0);
   end

endmodule

bind bankreg_file bankreg_file_chk #(
   .DATA_W      (DATA_W),
   .PC_ALIGN_EN (PC_ALIGN_EN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_i       (mode_i),
   .narrow_isa_i (narrow_isa_i),
   .rd_a_idx     (rd_a_idx),
   .rd_a_data    (rd_a_data),
   .rd_b_idx     (rd_b_idx),
   .rd_b_data    (rd_b_data),
   .wr_en        (wr_en),
   .wr_idx       (wr_idx),
   .wr_data      (wr_data),
   .aux_wr_en    (aux_wr_en),
   .aux_wr_mode  (aux_wr_mode),
   .aux_wr_data  (aux_wr_data),
   .sv_rd_data   (sv_rd_data),
   .sv_wr_en     (sv_wr_en),
   .sv_wr_data   (sv_wr_data)
);

// File: tb/bankreg_file_bench.sv
`timescale 1ns/1ps
module bankreg_file_bench;
   import bankreg_pkg::*;

   localparam real CLK_NS = 8.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  mode_i = MD_USER;
   logic        narrow_isa_i = 1'b0;
   logic [3:0]  rd_a_idx = '0;
   logic [31:0] rd_a_data;
   logic [3:0]  rd_b_idx = '0;
   logic [31:0] rd_b_data;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        aux_wr_en = 1'b0;
   logic [4:0]  aux_wr_mode = MD_USER;
   logic [31:0] aux_wr_data = '0;
   logic [31:0] sv_rd_data;
   logic        sv_wr_en = 1'b0;
   logic [31:0] sv_wr_data = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [4:0] pair_modes [4] = '{MD_INTR, MD_SUPV, MD_ABORT, MD_UNDEF};
   logic [4:0] exc_modes  [5] = '{MD_FAST, MD_INTR, MD_SUPV, MD_ABORT, MD_UNDEF};

   always #(CLK_NS / 2.0) clk = ~clk;

   bankreg_file u_bankreg_file (
      .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .narrow_isa_i (narrow_isa_i),
      .rd_a_idx (rd_a_idx), .rd_a_data (rd_a_data),
      .rd_b_idx (rd_b_idx), .rd_b_data (rd_b_data),
      .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
      .aux_wr_en (aux_wr_en), .aux_wr_mode (aux_wr_mode), .aux_wr_data (aux_wr_data),
      .sv_rd_data (sv_rd_data), .sv_wr_en (sv_wr_en), .sv_wr_data (sv_wr_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
      @(negedge clk);
      mode_i = m; wr_en = 1'b1; wr_idx = i; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [4:0] m, input logic [3:0] i,
                         input logic [31:0] exp);
      mode_i = m; rd_a_idx = i; rd_b_idx = i;
      #1;
      chk({req, " portA"}, rd_a_data, exp);
      chk({req, " portB"}, rd_b_data, exp);
   endtask

   task automatic sv_wr(input logic [4:0] m, input logic [31:0] d);
      @(negedge clk);
      mode_i = m; sv_wr_en = 1'b1; sv_wr_data = d;
      @(negedge clk);
      sv_wr_en = 1'b0;
   endtask

   task automatic sv_chk(input string req, input logic [4:0] m, input logic [31:0] exp);
      mode_i = m;
      #1;
      chk(req, sv_rd_data, exp);
   endtask

   // R1
   task automatic t_reset();
      rd_chk("R1 user r0", MD_USER, 4'd0, 32'h0);
      rd_chk("R1 fast r14", MD_FAST, 4'd14, 32'h0);
      rd_chk("R1 supv r13", MD_SUPV, 4'd13, 32'h0);
      sv_chk("R1 supv saved", MD_SUPV, 32'h0);
      sv_chk("R1 fast saved", MD_FAST, 32'h0);
   endtask

   // R2
   task automatic t_fill_user();
      for (int i = 0; i < 15; i++) do_wr(MD_USER, 4'(i), 32'h1000_0000 | 32'(i));
      for (int i = 0; i < 15; i += 7) rd_chk("R2 user readback", MD_USER, 4'(i), 32'h1000_0000 | 32'(i));
   endtask

   // R2
   task automatic t_same_cycle();
      @(negedge clk);
      mode_i = MD_USER; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h3333_0000;
      rd_a_idx = 4'd3;
      #1;
      chk("R2 old value before edge", rd_a_data, 32'h1000_0003);
      @(posedge clk);
      #1;
      chk("R2 new value after edge", rd_a_data, 32'h3333_0000);
      wr_en = 1'b0;
   endtask

   // R3
   task automatic t_system();
      do_wr(MD_SYSTEM, 4'd5, 32'h5555_5555);
      rd_chk("R3 system write seen in user", MD_USER, 4'd5, 32'h5555_5555);
      rd_chk("R3 unknown code sees user r5", 5'b00000, 4'd5, 32'h5555_5555);
      rd_chk("R3 unknown code sees user r13", 5'b01010, 4'd13, 32'h1000_000D);
      rd_chk("R3 system sees user r14", MD_SYSTEM, 4'd14, 32'h1000_000E);
   endtask

   // R4
   task automatic t_fast();
      for (int i = 8; i < 15; i++) do_wr(MD_FAST, 4'(i), 32'h2000_0000 | 32'(i));
      for (int i = 8; i < 15; i++) begin
         rd_chk("R4 fast private", MD_FAST, 4'(i), 32'h2000_0000 | 32'(i));
         rd_chk("R4 user untouched", MD_USER, 4'(i), 32'h1000_0000 | 32'(i));
      end
      rd_chk("R4 fast shares r2", MD_FAST, 4'd2, 32'h1000_0002);
      do_wr(MD_FAST, 4'd7, 32'h7777_0007);
      rd_chk("R4 fast r7 write shared", MD_USER, 4'd7, 32'h7777_0007);
      rd_chk("R4 intr sees user r12", MD_INTR, 4'd12, 32'h1000_000C);
   endtask

   // R5
   task automatic t_pairs();
      for (int k = 0; k < 4; k++) begin
         do_wr(pair_modes[k], 4'd13, 32'h3000_0000 | (32'(k) << 8) | 32'd13);
         do_wr(pair_modes[k], 4'd14, 32'h3000_0000 | (32'(k) << 8) | 32'd14);
      end
      for (int k = 0; k < 4; k++) begin
         rd_chk("R5 private r13", pair_modes[k], 4'd13, 32'h3000_0000 | (32'(k) << 8) | 32'd13);
         rd_chk("R5 private r14", pair_modes[k], 4'd14, 32'h3000_0000 | (32'(k) << 8) | 32'd14);
         rd_chk("R5 shared r12", pair_modes[k], 4'd12, 32'h1000_000C);
      end
      rd_chk("R5 user r13 intact", MD_USER, 4'd13, 32'h1000_000D);
      rd_chk("R5 fast r13 intact", MD_FAST, 4'd13, 32'h2000_000D);
      do_wr(MD_ABORT, 4'd9, 32'h9999_0009);
      rd_chk("R5 abort r9 is shared", MD_USER, 4'd9, 32'h9999_0009);
   endtask

   // R6
   task automatic t_pc();
      do_wr(MD_USER, 4'd15, 32'hABCD_0007);
      narrow_isa_i = 1'b0;
      rd_chk("R6 wide pc", MD_USER, 4'd15, 32'hABCD_0004);
      narrow_isa_i = 1'b1;
      rd_chk("R6 narrow pc", MD_USER, 4'd15, 32'hABCD_0006);
      rd_chk("R6 narrow pc shared by fast", MD_FAST, 4'd15, 32'hABCD_0006);
      rd_chk("R6 r14 not masked", MD_USER, 4'd14, 32'h1000_000E);
      narrow_isa_i = 1'b0;
      rd_chk("R6 wide pc in supv", MD_SUPV, 4'd15, 32'hABCD_0004);
   endtask

   // R7
   task automatic t_saved();
      for (int k = 0; k < 5; k++) sv_wr(exc_modes[k], 32'h5000_0000 | 32'(k));
      for (int k = 0; k < 5; k++) sv_chk("R7 saved per mode", exc_modes[k], 32'h5000_0000 | 32'(k));
   endtask

   // R8
   task automatic t_saved_user();
      sv_wr(MD_USER, 32'hDEAD_BEEF);
      sv_chk("R8 user saved reads zero", MD_USER, 32'h0);
      sv_wr(MD_SYSTEM, 32'hFEED_0001);
      sv_chk("R8 system saved reads zero", MD_SYSTEM, 32'h0);
      sv_wr(5'b00011, 32'hFEED_0002);
      for (int k = 0; k < 5; k++) sv_chk("R8 exception saved unchanged", exc_modes[k], 32'h5000_0000 | 32'(k));
   endtask

   // R9
   task automatic t_aux();
      @(negedge clk);
      mode_i = MD_USER; wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h2222_AAAA;
      aux_wr_en = 1'b1; aux_wr_mode = MD_INTR; aux_wr_data = 32'h9000_0001;
      @(negedge clk);
      wr_en = 1'b0; aux_wr_en = 1'b0;
      rd_chk("R9 main write same cycle", MD_USER, 4'd2, 32'h2222_AAAA);
      rd_chk("R9 aux wrote intr lr", MD_INTR, 4'd14, 32'h9000_0001);
      rd_chk("R9 supv lr untouched", MD_SUPV, 4'd14, 32'h3000_010E);
      @(negedge clk);
      mode_i = MD_SUPV; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h1111_1111;
      aux_wr_en = 1'b1; aux_wr_mode = MD_SUPV; aux_wr_data = 32'h9000_0002;
      @(negedge clk);
      wr_en = 1'b0; aux_wr_en = 1'b0;
      rd_chk("R9 aux wins collision", MD_SUPV, 4'd14, 32'h9000_0002);
      @(negedge clk);
      aux_wr_en = 1'b1; aux_wr_mode = MD_SYSTEM; aux_wr_data = 32'h9000_0003;
      @(negedge clk);
      aux_wr_en = 1'b0;
      rd_chk("R9 aux system mode hits user lr", MD_USER, 4'd14, 32'h9000_0003);
      rd_chk("R9 fast lr untouched", MD_FAST, 4'd14, 32'h2000_000E);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill_user();
      t_same_cycle();
      t_system();
      t_fast();
      t_pairs();
      t_pc();
      t_saved();
      t_saved_user();
      t_aux();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000.0);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog all-reqs act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule